// File: doc/BRIEF.md
# Two-of-Three Sliding Window Serial Detector

This block watches a one-bit serial stream and raises a flag whenever exactly two of the three most recent bits are 1. The bit offered in the current cycle counts as the newest member of the window. A bit only counts when a valid strobe marks it. Each accepted bit slides the window by one position, so the detector never needs to resynchronise.

After reset the block holds no history. It counts how many bits it has accepted, and it keeps the flag low until two bits are stored and a third is being offered. The flag is a Mealy output: it combines the stored history with the present input. While the strobe is low the flag is held at 0, and both the history and the fill count keep their values.

The reset input is asynchronous and active low. Asserting it clears the block at once. Release is passed through a short synchroniser, so the block leaves reset only on a clock edge.

Top module: `twin_detect`

## Requirements
- R1: With at least two bits accepted since reset and `bit_valid` high, `detect` is 1 in the same cycle when the window (older stored bit, newer stored bit, `bit_in`) reads 011, 101 or 110.
- R2: A window of 111 gives `detect` = 0.
- R3: A window holding fewer than two ones (000, 001, 010, 100) gives `detect` = 0.
- R4: `bit_in` is part of the window. Changing it within a cycle changes `detect` in that same cycle, with no clock edge in between.
- R5: After reset, `detect` stays 0 while the first and second accepted bits are offered, whatever their values. It may first rise while the third accepted bit is offered.
- R6: While `bit_valid` is 0, `detect` is 0. The history and the fill count are unchanged, so the next accepted bit sees the same window it would have seen with no gap.
- R7: Driving `rst_n` to 0 forces `detect` to 0 at once, without a clock edge, and discards both history and fill count. After `rst_n` returns to 1, the block accepts bits from the third rising edge onward.
- R8: For the accepted stream 0,1,1,0,1,1,1,0,0 offered right after reset, `detect` reads 0,0,1,1,1,1,0,1,0.
- R9: Over a long unbroken run of accepted bits, every cycle after warm-up follows the rule in R1 to R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_valid | input | 1 | High when `bit_in` carries a bit to accept |
| bit_in | input | 1 | Serial data bit |
| detect | output | 1 | High when exactly two of the last three bits are 1 |

## Verification
`detect` is combinational from the present input and the stored state, so it is due in the same cycle the bit is offered. A rising edge then commits that bit to the history, and the new history is visible from the following cycle. The bench therefore changes the inputs on the falling edge and reads `detect` 4 ns later, before the next rising edge commits the bit. The two exceptions are the asynchronous reset check, which reads the output 1 ns after `rst_n` falls with no edge in between, and the release check, which waits three falling edges for the two-stage synchroniser.

// File: rtl/twin_pkg.sv
package twin_pkg;

  // Number of set bits in a window vector of up to 32 bits.
  function automatic int unsigned ones_in(input logic [31:0] vec, input int unsigned len);
    int unsigned acc;
    acc = 0;
    for (int unsigned k = 0; k < 32; k++) begin
      if (k < len) acc += vec[k] ? 1 : 0;
    end
    return acc;
  endfunction

endpackage

// File: rtl/twin_rst_sync.sv
module twin_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/twin_history.sv
module twin_history #(
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [DEPTH-1:0] hist
);
  logic [DEPTH-1:0] hist_q;
  logic [DEPTH-1:0] hist_d;

  generate
    if (DEPTH == 1) begin : g_one
      always_comb begin
        hist_d = hist_q;
        if (shift_en) hist_d = bit_in;
      end
    end else begin : g_many
      always_comb begin
        hist_d = hist_q;
        if (shift_en) hist_d = {hist_q[DEPTH-2:0], bit_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  assign hist = hist_q;
endmodule

// File: rtl/twin_fill_ctr.sv
module twin_fill_ctr #(
  parameter int LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic full
);
  localparam int CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          at_lim;

  assign at_lim = (cnt_q == LIM);

  always_comb begin
    cnt_d = cnt_q;
    if (step && !at_lim) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign full = at_lim;
endmodule

// File: rtl/twin_decide.sv
module twin_decide #(
  parameter int WIN    = 3,
  parameter int TARGET = 2
) (
  input  logic           valid,
  input  logic           full,
  input  logic [WIN-2:0] hist,
  input  logic           bit_in,
  output logic           hit
);
  import twin_pkg::*;

  logic [WIN-1:0] window;
  logic [31:0]    window_ext;
  int unsigned    ones;

  assign window     = {hist, bit_in};
  assign window_ext = 32'(window);

  always_comb begin
    ones = ones_in(window_ext, WIN);
    hit  = valid && full && (ones == TARGET);
  end
endmodule

// File: rtl/twin_detect.sv
module twin_detect #(
  parameter int WIN         = 3,
  parameter int TARGET      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic bit_in,
  output logic detect
);
  localparam int DEPTH = WIN - 1;

  logic             rst_sync_n;
  logic [DEPTH-1:0] hist;
  logic             full;
  logic             accept;

  assign accept = bit_valid;

  twin_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  twin_history #(.DEPTH(DEPTH)) u_hist (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .shift_en (accept),
    .bit_in   (bit_in),
    .hist     (hist)
  );

  twin_fill_ctr #(.LIMIT(DEPTH)) u_fill (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .step  (accept),
    .full  (full)
  );

  twin_decide #(.WIN(WIN), .TARGET(TARGET)) u_dec (
    .valid  (bit_valid),
    .full   (full),
    .hist   (hist),
    .bit_in (bit_in),
    .hit    (detect)
  );
endmodule

// File: rtl/twin_detect_chk.sv
module twin_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_valid,
  input logic bit_in,
  input logic detect
);
  logic [1:0] seen_q;
  logic [1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      last_q <= '0;
    end else if (bit_valid) begin
      if (seen_q != 2'd2) seen_q <= seen_q + 2'd1;
      last_q <= {last_q[0], bit_in};
    end
  end

  p_pair_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && seen_q == 2'd2 && $countones({last_q, bit_in}) == 2) |-> detect);

  p_all_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && bit_in && last_q == 2'b11) |-> !detect);

  p_sparse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && $countones({last_q, bit_in}) < 2) |-> !detect);

  p_warmup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q != 2'd2) |-> !detect);

  p_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |-> !detect);
endmodule

bind twin_detect twin_detect_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bit_valid (bit_valid),
  .bit_in    (bit_in),
  .detect    (detect)
);

// File: tb/twin_detect_test.sv
`timescale 1ns/1ps
module twin_detect_test;
  logic clk;
  logic rst_n;
  logic bit_valid;
  logic bit_in;
  logic detect;

  int checks;
  int errors;
  bit done;

  // each row: {valid, din, expected detect}
  localparam int NV = 20;
  localparam logic [2:0] VEC [NV] = '{
    3'b100, 3'b110, 3'b111, 3'b101, 3'b111, 3'b111, 3'b110, 3'b101, 3'b100,
    3'b010, 3'b100, 3'b110, 3'b010, 3'b100, 3'b111, 3'b111, 3'b000, 3'b110,
    3'b101, 3'b100
  };

  twin_detect uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (bit_valid),
    .bit_in    (bit_in),
    .detect    (detect)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: detect=%0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic offer(input logic v, input logic d, input logic exp, input string req);
    @(negedge clk);
    bit_valid = v;
    bit_in    = d;
    #4;
    check(detect, exp, req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bit_valid = 1'b0;
    bit_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done = 1'b0;
    rst_n = 1'b0;
    bit_valid = 1'b0;
    bit_in = 1'b0;

    // R7: output low while reset held, even with a strobed 1
    @(negedge clk);
    bit_valid = 1'b1;
    bit_in = 1'b1;
    #4;
    check(detect, 1'b0, "R7");
    do_reset();
    #4;
    check(detect, 1'b0, "R7");

    // vector table: R8 stream, then gaps (R6), R1/R2/R3 windows, R5 warm-up
    for (int i = 0; i < NV; i++) begin
      string tag;
      if (i < 2)               tag = "R5";
      else if (i < 9)          tag = "R8";
      else if (!VEC[i][2])     tag = "R6";
      else if (VEC[i][0])      tag = "R1";
      else if (VEC[i][1] && i == 17) tag = "R2";
      else                     tag = "R3";
      offer(VEC[i][2], VEC[i][1], VEC[i][0], tag);
    end

    // R4: history now 0,0 -> build 1,0 then flip bit_in within one cycle
    offer(1'b1, 1'b1, 1'b0, "R3");
    offer(1'b1, 1'b0, 1'b0, "R3");
    @(negedge clk);
    bit_valid = 1'b1;
    bit_in = 1'b1;
    #2;
    check(detect, 1'b1, "R4");
    bit_in = 1'b0;
    #1;
    check(detect, 1'b0, "R4");
    bit_in = 1'b1;
    #1;
    check(detect, 1'b1, "R4");

    // R7: asynchronous reset mid-stream discards history
    do_reset();
    offer(1'b1, 1'b0, 1'b0, "R5");
    offer(1'b1, 1'b1, 1'b0, "R5");
    @(negedge clk);
    bit_valid = 1'b1;
    bit_in = 1'b1;
    #2;
    check(detect, 1'b1, "R1");
    rst_n = 1'b0;
    #1;
    check(detect, 1'b0, "R7");
    @(negedge clk);
    bit_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    offer(1'b1, 1'b1, 1'b0, "R7");
    offer(1'b1, 1'b1, 1'b0, "R7");
    offer(1'b1, 1'b0, 1'b1, "R7");

    // R6: gap where the window would have matched
    offer(1'b0, 1'b1, 1'b0, "R6");
    offer(1'b1, 1'b1, 1'b1, "R6");

    // R9: long unbroken pseudo-random run with a bench-side model
    do_reset();
    begin
      logic [15:0] lfsr;
      logic o2, o1;
      int n;
      lfsr = 16'hACE1;
      o2 = 1'b0;
      o1 = 1'b0;
      n = 0;
      for (int k = 0; k < 400; k++) begin
        logic d;
        logic e;
        d = lfsr[0];
        e = (n >= 2) && ((int'(o2) + int'(o1) + int'(d)) == 2);
        offer(1'b1, d, e, "R9");
        o2 = o1;
        o1 = d;
        if (n < 2) n++;
        lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule